// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It compares two operand registers with a single subtractor that computes A plus the inverse of B plus one. From that one subtraction it derives four flags: zero, unsigned borrow, signed overflow and signed less-than. A small decision stage maps a 3-bit branch-type code onto those flags and produces the taken decision.

The taken decision is qualified by a valid strobe. The branch-type code uses the integer funct3 encoding. The two unassigned codes are reported as illegal and never produce a taken branch. The flags are also brought out for debug.

A parameter selects whether the results leave through an output register, which is the default, or straight from the combinational logic. The subtractor is built from a low part and a separate most-significant-bit stage, so the carry into the MSB and the carry out of it are both explicit. Two independent paths cross-check the main one: an XOR-based equality detector and a sign-extended wide subtraction.

Top module: `branch_cond_unit`

## Requirements
- R1: Code 000 (equal) is taken exactly when the zero flag of A minus B is set. Code 001 (not equal) is taken exactly when that flag is clear. zero_o is 1 exactly when A equals B.
- R2: borrow_o is 1 exactly when A is below B as unsigned numbers, so A=1 and B=2 give borrow_o=1. It is the inverse of the adder carry out.
- R3: Code 110 (unsigned less-than) is taken when borrow_o=1. Code 111 (unsigned greater-or-equal) is taken when borrow_o=0.
- R4: ovf_o is the XOR of the carry into the MSB and the carry out of the MSB of A plus ~B plus 1. It is 1 exactly when A minus B overflows as a signed number.
- R5: slt_o equals ovf_o XOR the result's MSB, and is 1 exactly when A is below B as signed numbers. This holds for A=0x80000000 with B=0x7FFFFFFF, where the MSB of the result alone gives the wrong answer. Code 100 is taken when slt_o=1, and code 101 when slt_o=0.
- R6: slt_o equals bit 32 of the difference of the two operands sign-extended to 33 bits, for every input.
- R7: The reduction-NOR of A XOR B equals zero_o for every operand pair.
- R8: Codes 010 and 011 force taken_o=0 and set illegal_o=1 while valid_i is high.
- R9: With valid_i low, taken_o and illegal_o are 0 whatever the operands and code are. The flags still follow the operands.
- R10: With REG_OUT=1, every output shows the result for the inputs at the previous rising clock edge. While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Branch evaluation request |
| op_a_i | input | WIDTH | First operand (A) |
| op_b_i | input | WIDTH | Second operand (B) |
| br_type_i | input | 3 | Branch type, funct3 encoding |
| taken_o | output | 1 | Branch taken decision |
| illegal_o | output | 1 | Unassigned branch-type code with valid_i high |
| zero_o | output | 1 | Debug: A minus B is zero |
| borrow_o | output | 1 | Debug: unsigned borrow |
| ovf_o | output | 1 | Debug: signed overflow |
| slt_o | output | 1 | Debug: signed less-than |

## Verification
With the default registered output, every result is due one rising edge after its inputs are applied. The bench drives on the falling edge and samples shortly after the following rising edge, so each comparison sees exactly the vector it stimulated. One directed check samples just before that edge to confirm the previous value is still held. The reset check samples mid-cycle while rst_ni is low. The cross-check assertions compare the combinational paths inside the same cycle as their operands.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [2:0] {
    BR_EQ   = 3'b000,
    BR_NE   = 3'b001,
    BR_RSV2 = 3'b010,
    BR_RSV3 = 3'b011,
    BR_LT   = 3'b100,
    BR_GE   = 3'b101,
    BR_LTU  = 3'b110,
    BR_GEU  = 3'b111
  } br_type_e;

  typedef struct packed {
    logic zero;
    logic borrow;
    logic ovf;
    logic slt;
  } cmp_flags_t;
endpackage

// File: rtl/bcc_subtractor.sv
module bcc_subtractor #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output bcc_pkg::cmp_flags_t flags_o,
  output logic [WIDTH-1:0]   diff_o
);
  localparam int LW = WIDTH - 1;

  logic [LW:0]  low_sum;   // bit LW is carry into MSB
  logic         c_msb_in;
  logic         c_msb_out;
  logic         a_msb, nb_msb;

  assign low_sum   = {1'b0, a_i[LW-1:0]} + {1'b0, ~b_i[LW-1:0]} + {{LW{1'b0}}, 1'b1};
  assign c_msb_in  = low_sum[LW];
  assign a_msb     = a_i[LW];
  assign nb_msb    = ~b_i[LW];
  assign c_msb_out = (a_msb & nb_msb) | (a_msb & c_msb_in) | (nb_msb & c_msb_in);
  assign diff_o    = {a_msb ^ nb_msb ^ c_msb_in, low_sum[LW-1:0]};

  assign flags_o.zero   = ~|diff_o;
  assign flags_o.borrow = ~c_msb_out;
  assign flags_o.ovf    = c_msb_in ^ c_msb_out;
  assign flags_o.slt    = flags_o.ovf ^ diff_o[LW];
endmodule

// File: rtl/bcc_eq_detect.sv
module bcc_eq_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             eq_o,
  output logic             slt_wide_o
);
  logic [WIDTH:0] wide_diff;

  assign eq_o       = ~|(a_i ^ b_i);
  assign wide_diff  = {a_i[WIDTH-1], a_i} - {b_i[WIDTH-1], b_i};
  assign slt_wide_o = wide_diff[WIDTH];
endmodule

// File: rtl/bcc_decide.sv
module bcc_decide
  import bcc_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] br_type_i,
  input  cmp_flags_t flags_i,
  output logic       taken_o,
  output logic       illegal_o
);
  br_type_e br_type;
  logic     cond;
  logic     rsv;

  assign br_type = br_type_e'(br_type_i);

  always_comb begin
    cond = 1'b0;
    rsv  = 1'b0;
    unique case (br_type)
      BR_EQ:   cond = flags_i.zero;
      BR_NE:   cond = ~flags_i.zero;
      BR_LT:   cond = flags_i.slt;
      BR_GE:   cond = ~flags_i.slt;
      BR_LTU:  cond = flags_i.borrow;
      BR_GEU:  cond = ~flags_i.borrow;
      default: rsv  = 1'b1;
    endcase
  end

  assign taken_o   = valid_i & cond;
  assign illegal_o = valid_i & rsv;
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
  import bcc_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [2:0]       br_type_i,
  output logic             taken_o,
  output logic             illegal_o,
  output logic             zero_o,
  output logic             borrow_o,
  output logic             ovf_o,
  output logic             slt_o
);
  cmp_flags_t       flags_c;
  logic [WIDTH-1:0] diff_c;
  logic             eq_xor_c, slt_wide_c;
  logic             taken_c, illegal_c;

  bcc_subtractor #(.WIDTH(WIDTH)) u_sub (
    .a_i(op_a_i), .b_i(op_b_i), .flags_o(flags_c), .diff_o(diff_c)
  );

  bcc_eq_detect #(.WIDTH(WIDTH)) u_eq (
    .a_i(op_a_i), .b_i(op_b_i), .eq_o(eq_xor_c), .slt_wide_o(slt_wide_c)
  );

  bcc_decide u_dec (
    .valid_i(valid_i), .br_type_i(br_type_i), .flags_i(flags_c),
    .taken_o(taken_c), .illegal_o(illegal_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        taken_o   <= 1'b0;
        illegal_o <= 1'b0;
        zero_o    <= 1'b0;
        borrow_o  <= 1'b0;
        ovf_o     <= 1'b0;
        slt_o     <= 1'b0;
      end else begin
        taken_o   <= taken_c;
        illegal_o <= illegal_c;
        zero_o    <= flags_c.zero;
        borrow_o  <= flags_c.borrow;
        ovf_o     <= flags_c.ovf;
        slt_o     <= flags_c.slt;
      end
    end

    a_r10_idle_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!taken_o && !illegal_o));
  end else begin : g_comb
    assign taken_o   = taken_c;
    assign illegal_o = illegal_c;
    assign zero_o    = flags_c.zero;
    assign borrow_o  = flags_c.borrow;
    assign ovf_o     = flags_c.ovf;
    assign slt_o     = flags_c.slt;
  end

  a_r1_eq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && br_type_i == 3'b000) |-> (taken_c == (op_a_i == op_b_i)));
  a_r2_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_c.borrow == (op_a_i < op_b_i));
  a_r6_slt_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_c.slt == slt_wide_c);
  a_r7_eq_xor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_xor_c == flags_c.zero);
  a_r8_illegal_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_c |-> !taken_c);
  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!taken_c && !illegal_c));
  a_r4_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_c.ovf == ((op_a_i[WIDTH-1] != op_b_i[WIDTH-1]) &&
                    (diff_c[WIDTH-1] != op_a_i[WIDTH-1])));
endmodule

// File: tb/branch_cond_unit_test.sv
`timescale 1ns/1ps
module branch_cond_unit_test;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] op_a_i = '0, op_b_i = '0;
  logic [2:0]   br_type_i = 3'b000;
  logic taken_o, illegal_o, zero_o, borrow_o, ovf_o, slt_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  branch_cond_unit #(.WIDTH(W), .REG_OUT(1'b1)) uut (
    .clk_i, .rst_ni, .valid_i, .op_a_i, .op_b_i, .br_type_i,
    .taken_o, .illegal_o, .zero_o, .borrow_o, .ovf_o, .slt_o
  );

  function automatic logic ref_slt(logic [W-1:0] a, logic [W-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  function automatic logic ref_ovf(logic [W-1:0] a, logic [W-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint d  = sa - sb;
    return (d > 64'sd2147483647) || (d < -64'sd2147483648);
  endfunction

  function automatic logic ref_taken(logic v, logic [2:0] t, logic [W-1:0] a, logic [W-1:0] b);
    if (!v) return 1'b0;
    case (t)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return ref_slt(a, b);
      3'b101:  return !ref_slt(a, b);
      3'b110:  return a < b;
      3'b111:  return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic apply(logic v, logic [2:0] t, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk_i);
    valid_i = v; br_type_i = t; op_a_i = a; op_b_i = b;
    @(posedge clk_i);
    #1;
    chk("R1 zero", zero_o, a == b);
    chk("R2 borrow", borrow_o, a < b);
    chk("R4 ovf", ovf_o, ref_ovf(a, b));
    chk("R5 R6 slt", slt_o, ref_slt(a, b));
    chk("R3 R5 R9 taken", taken_o, ref_taken(v, t, a, b));
    chk("R8 R9 illegal", illegal_o, v && (t == 3'b010 || t == 3'b011));
  endtask

  task automatic all_types(logic [W-1:0] a, logic [W-1:0] b);
    for (int t = 0; t < 8; t++) apply(1'b1, 3'(t), a, b);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R10: outputs cleared during reset
    valid_i = 1'b1; op_a_i = 32'd5; op_b_i = 32'd5;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R10 reset taken", taken_o, 1'b0);
    chk("R10 reset zero", zero_o, 1'b0);
    chk("R10 reset illegal", illegal_o, 1'b0);
    rst_ni = 1'b1;

    // corner pairs, every code (R1 R2 R3 R4 R5 R8)
    all_types(32'h7FFF_FFFF, 32'h8000_0000);
    all_types(32'h8000_0000, 32'h7FFF_FFFF);
    all_types(32'h0000_0000, 32'hFFFF_FFFF);
    all_types(32'hFFFF_FFFF, 32'h0000_0000);
    all_types(32'h1234_5678, 32'h1234_5678);
    all_types(32'd1, 32'd2);
    all_types(32'hFFFF_FFFF, 32'hFFFF_FFFE);

    // R9: valid low ignores operands and code
    apply(1'b0, 3'b000, 32'd7, 32'd7);
    apply(1'b0, 3'b010, 32'd3, 32'd9);
    apply(1'b0, 3'b111, 32'd9, 32'd3);

    // R10: one clock of latency
    @(negedge clk_i);
    valid_i = 1'b1; br_type_i = 3'b000; op_a_i = 32'd4; op_b_i = 32'd4;
    #1;
    chk("R10 before edge", taken_o, 1'b0);
    @(posedge clk_i);
    #1;
    chk("R10 after edge", taken_o, 1'b1);

    // random operands, with extra equal and near-equal pairs
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a = $urandom;
      logic [W-1:0] b = $urandom;
      logic [2:0]   t = 3'($urandom);
      logic         v = ($urandom % 8) != 0;
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) b = a ^ 32'h8000_0000;
      apply(v, t, a, b);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule